// File: doc/BRIEF.md
# Unrolled Non-Restoring Integer Divider

This block divides an unsigned 8-bit dividend by an unsigned 8-bit divisor and returns an 8-bit quotient and an 8-bit remainder. It does not resolve one quotient bit per clock. Instead, four add-or-subtract steps of the non-restoring method are chained as combinational logic inside each cycle. The first half of the quotient is resolved in the cycle that carries the start request. The second half is resolved in the following cycle, and the remainder is fixed up at the end of that cycle if needed.

The block holds a signed partial remainder and a partly built quotient between the two cycles. Each stage sees the divisor through an XOR conditioner. That stage subtracts the divisor when the previous partial remainder is non-negative and adds it when that remainder is negative. The stage's quotient bit is the inverse of the sign of its new remainder.

A start pulse is taken while the block is not busy. The operands are captured at that edge, and done pulses once with the result two cycles after the request. A zero divisor does not stall the block and does not leave it in an undefined state. It returns a fixed pattern on the normal schedule.

Top module: `divUnrolled`

## Requirements
- R1: While reset is held and after it is released with no request, busy and done are 0 and quotient and remainder are 0.
- R2: For a non-zero divisor, quotient equals the integer part of dividend divided by divisor. For example, 105 divided by 26 gives a quotient of 4.
- R3: For a non-zero divisor, remainder equals dividend modulo divisor, so it is always smaller than the divisor. For example, 105 divided by 26 leaves 1. Between the two cycles of a divide, the held partial remainder stays within minus divisor and divisor (upper bound excluded).
- R4: A divisor of 0 returns quotient 0xFF (all ones) and a remainder equal to the dividend, with done on the normal schedule.
- R5: A start sampled high at a rising edge while busy is 0 is accepted. busy is then 1 during the next cycle, and done is 1 for exactly one cycle, following the second rising edge after acceptance. A new start may be accepted in the cycle where done is 1.
- R6: A start sampled while busy is 1 is ignored. Dividend and divisor changes after the accepting edge do not affect the result.
- R7: quotient and remainder keep their values after done until the next divide completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request for a divide; taken when busy is 0 |
| dividend | input | 8 | Unsigned dividend, captured on acceptance |
| divisor | input | 8 | Unsigned divisor, captured on acceptance |
| busy | output | 1 | High during the second cycle of a divide |
| done | output | 1 | One-cycle pulse when quotient and remainder are valid |
| quotient | output | 8 | Result quotient, held until the next completion |
| remainder | output | 8 | Result remainder, held until the next completion |

## Verification
The assertions assume three things about the inputs. First, start and the operands change only between clock edges. Second, the block's own timing keeps a new request from landing in the same cycle as the final half of a divide. Third, the divisor held for the final checks has not been replaced before the check cycle, which holds because acceptance needs busy low.

The stimulus keeps within these assumptions by driving every input on the falling edge. Every dividend and divisor pair is run back to back, launching each request in the done cycle of the one before. While busy is high, start is held high and the operand inputs are fed random junk to show they are ignored. A seeded random phase with random idle gaps then covers spacing between requests, the single-cycle width of done, and how long results are held.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;  // request accepted: chain takes fresh operands
    logic step;  // chain result is written back this edge
    logic last;  // this edge completes the divide
  } divStrobes_t;

endpackage

// File: rtl/divStage.sv
// One non-restoring step: shift in a dividend bit, then add or subtract the
// divisor depending on the sign of the incoming partial remainder.
module divStage #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   remIn,
  input  logic             bitIn,
  input  logic [WIDTH-1:0] dvIn,
  output logic [WIDTH:0]   remOut,
  output logic             qBit
);

  logic             doSub;
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   operand;

  always_comb begin
    doSub   = ~remIn[WIDTH];
    shifted = {remIn[WIDTH-1:0], bitIn};
    operand = {1'b0, dvIn} ^ {(WIDTH + 1){doSub}};
    remOut  = shifted + operand + {{WIDTH{1'b0}}, doSub};
    qBit    = ~remOut[WIDTH];
  end

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH           = 8,
  parameter int STAGES_PER_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       strobes,
  input  logic [WIDTH-1:0]  dividend,
  input  logic [WIDTH-1:0]  divisor,
  output logic [WIDTH-1:0]  quotient,
  output logic [WIDTH-1:0]  remainder
);

  localparam int S = STAGES_PER_STEP;

  // Held state between cycles.
  logic [WIDTH:0]   remReg;
  logic [WIDTH-1:0] numReg;
  logic [WIDTH-1:0] quoReg;
  logic [WIDTH-1:0] divisorReg;
  logic [WIDTH-1:0] origReg;
  logic             zeroReg;

  // Chain inputs: fresh operands on load, otherwise held state.
  logic [WIDTH:0]   remIn;
  logic [WIDTH-1:0] numIn;
  logic [WIDTH-1:0] quoIn;
  logic [WIDTH-1:0] dvIn;
  logic [WIDTH-1:0] origIn;
  logic             zeroIn;

  always_comb begin
    if (strobes.load) begin
      remIn  = '0;
      numIn  = dividend;
      quoIn  = '0;
      dvIn   = divisor;
      origIn = dividend;
      zeroIn = (divisor == '0);
    end else begin
      remIn  = remReg;
      numIn  = numReg;
      quoIn  = quoReg;
      dvIn   = divisorReg;
      origIn = origReg;
      zeroIn = zeroReg;
    end
  end

  // Four chained adders per cycle, no registers in between.
  logic [WIDTH:0] remChain [0:S];
  logic [S-1:0]   qBits;

  assign remChain[0] = remIn;

  for (genvar j = 0; j < S; j++) begin : g_stage
    divStage #(.WIDTH(WIDTH)) i_stage (
      .remIn (remChain[j]),
      .bitIn (numIn[WIDTH-1-j]),
      .dvIn  (dvIn),
      .remOut(remChain[j+1]),
      .qBit  (qBits[S-1-j])
    );
  end

  logic [WIDTH-1:0] quoNext;
  logic [WIDTH-1:0] numNext;
  logic [WIDTH:0]   remFixed;
  logic [WIDTH-1:0] quoFinal;
  logic [WIDTH-1:0] remFinal;

  always_comb begin
    quoNext  = {quoIn[WIDTH-S-1:0], qBits};
    numNext  = {numIn[WIDTH-S-1:0], {S{1'b0}}};
    remFixed = remChain[S][WIDTH] ? remChain[S] + {1'b0, dvIn} : remChain[S];
    quoFinal = zeroIn ? {WIDTH{1'b1}} : quoNext;
    remFinal = zeroIn ? origIn : remFixed[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg     <= '0;
      numReg     <= '0;
      quoReg     <= '0;
      divisorReg <= '0;
      origReg    <= '0;
      zeroReg    <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
    end else begin
      if (strobes.step) begin
        remReg <= remChain[S];
        numReg <= numNext;
        quoReg <= quoNext;
      end
      if (strobes.load) begin
        divisorReg <= dvIn;
        origReg    <= origIn;
        zeroReg    <= zeroIn;
      end
      if (strobes.last) begin
        quotient  <= quoFinal;
        remainder <= remFinal;
      end
    end
  end

  // Checks on the held state and the results.
  logic signed [WIDTH+1:0] remWide;
  logic signed [WIDTH+1:0] dvWide;
  logic        [2*WIDTH-1:0] rebuilt;

  always_comb begin
    remWide = {remReg[WIDTH], remReg};
    dvWide  = {2'b00, divisorReg};
    rebuilt = {{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, divisorReg}
            + {{WIDTH{1'b0}}, remainder};
  end

  // R3: held partial remainder stays inside [-divisor, divisor).
  assert_partial_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load && !zeroReg) |-> (remWide < dvWide && remWide + dvWide >= 0));

  // R3: final remainder is below the divisor.
  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |=> (zeroReg || remainder < divisorReg));

  // R2: quotient times divisor plus remainder rebuilds the dividend.
  assert_rebuild_dividend_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |=> (zeroReg || rebuilt == {{WIDTH{1'b0}}, origReg}));

  // R4: zero divisor gives all-ones quotient and the dividend back.
  assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |=> (!zeroReg || (quotient == {WIDTH{1'b1}} && remainder == origReg)));

  // R7: results only move on a completing edge.
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.last |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int STEPS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  logic             busyReg;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             finishNow;

  always_comb begin
    accept    = start && !busyReg;
    if (STEPS == 1) finishNow = accept;
    else            finishNow = busyReg && (cnt == LAST_CNT);
    strobes.load = accept;
    strobes.step = accept || busyReg;
    strobes.last = finishNow;
    busy         = busyReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyReg <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= finishNow;
      if (accept && STEPS > 1) begin
        busyReg <= 1'b1;
        cnt     <= CNT_W'(1);
      end else if (busyReg) begin
        if (cnt == LAST_CNT) begin
          busyReg <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  if (STEPS > 1) begin : g_seq_checks
    // R5: done is a single-cycle pulse.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
      done |=> !done);

    // R5: done only follows a busy cycle.
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
      done |-> $past(busyReg));

    // R6: busy only rises on a start request.
    assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(busyReg) |-> $past(start));
  end

endmodule

// File: rtl/divUnrolled.sv
module divUnrolled
  import divPkg::*;
#(
  parameter int WIDTH           = 8,
  parameter int STAGES_PER_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int STEPS = WIDTH / STAGES_PER_STEP;

  divStrobes_t strobes;

  divControl #(.STEPS(STEPS)) i_control (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  divDatapath #(
    .WIDTH          (WIDTH),
    .STAGES_PER_STEP(STAGES_PER_STEP)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .remainder(remainder)
  );

endmodule

// File: tb/test_divUnrolled.sv
module test_divUnrolled;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic [7:0] divisor = '0;
  logic       busy;
  logic       done;
  logic [7:0] quotient;
  logic [7:0] remainder;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  divUnrolled i_divUnrolled (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expQ(input int n, input int d);
    return (d == 0) ? 255 : n / d;
  endfunction

  function automatic int expR(input int n, input int d);
    return (d == 0) ? n : n % d;
  endfunction

  // Called at a falling edge; returns at the falling edge of the done cycle.
  task automatic runDiv(input int n, input int d, input bit junkStart);
    start = 1'b1; dividend = 8'(n); divisor = 8'(d);
    @(posedge clk); @(negedge clk);
    chk(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
    chk(done == 1'b0, "R5 done early", int'(done), 0);
    // R6: start and operand changes while busy must be ignored
    start = junkStart; dividend = 8'($urandom); divisor = 8'($urandom);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, "R5 done on second edge", int'(done), 1);
    if (d == 0) begin
      chk(int'(quotient) == 255, "R4 quotient", int'(quotient), 255);
      chk(int'(remainder) == n, "R4 remainder", int'(remainder), n);
    end else begin
      chk(int'(quotient) == expQ(n, d), "R2 quotient", int'(quotient), expQ(n, d));
      chk(int'(remainder) == expR(n, d), "R3 remainder", int'(remainder), expR(n, d));
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1d1e_5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(quotient == 8'd0, "R1 quotient", int'(quotient), 0);
    chk(remainder == 8'd0, "R1 remainder", int'(remainder), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after release", int'({busy, done}), 0);

    // Directed: 105 / 26 -> 4 rem 1 (R2, R3)
    runDiv(105, 26, 1'b0);
    chk(quotient == 8'd4, "R2 directed 105/26", int'(quotient), 4);
    chk(remainder == 8'd1, "R3 directed 105/26", int'(remainder), 1);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
    // R7: results held while idle
    repeat (3) @(negedge clk);
    chk(quotient == 8'd4 && remainder == 8'd1, "R7 hold while idle",
        int'({quotient, remainder}), int'({8'd4, 8'd1}));

    // Exhaustive sweep, back to back, with ignored starts while busy (R6)
    for (int n = 0; n < 256; n++) begin
      for (int d = 0; d < 256; d++) begin
        runDiv(n, d, 1'b1);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R5 done drops after sweep", int'(done), 0);

    // Seeded random phase with idle gaps
    for (int k = 0; k < 300; k++) begin
      int n = int'($urandom_range(255));
      int d = (k % 17 == 0) ? 0 : int'($urandom_range(255));
      int gap = int'($urandom_range(2));
      runDiv(n, d, k[0]);
      repeat (gap) begin
        @(negedge clk);
        chk(done == 1'b0, "R5 no repeat done", int'(done), 0);
        chk(int'(quotient) == expQ(n, d) && int'(remainder) == expR(n, d), "R7 hold in gap",
            int'({quotient, remainder}), (expQ(n, d) << 8) | expR(n, d));
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule